// File: doc/BRIEF.md
# Multi-Core Interrupt Distribution Unit

This block takes a set of shared external interrupt lines and steers each one to the cores of a multi-core cluster. Each shared line has its own configuration: a destination core mask, a distribution mode, and a mask bit. Every core has one uplink for each shared line. Shared line `i` therefore appears on uplink `i` of whichever core it is routed to.

Configuration arrives over a single-cycle command port. A command carries an opcode, the number of the shared line it addresses, and a data word. A global enable gates every uplink.

In fixed mode a line goes to exactly one core. In rotating mode each new assertion of the line is given to the next core of its mask, so that interrupt load is spread across the cores. The routed output is registered, so it follows the input level one cycle later.

Top module: `idu_top`

## Requirements
- R1: After reset every uplink is low, every shared line is masked with an empty destination mask, and the global enable is off. A line raised before any configuration drives no uplink.
- R2: Opcode 1 (enable) turns the global enable on when the data word is nonzero and off when it is zero. While the enable is off every uplink is low.
- R3: Opcode 4 (mask) masks the addressed line when the data word is nonzero and unmasks it when it is zero. A masked line drives no uplink from the cycle after the mask takes effect.
- R4: Opcode 2 (destination) writes data bits [NUM_CORE-1:0] as the core mask of the addressed line, bit k standing for core k. In fixed mode only the lowest set bit of the mask receives the line.
- R5: In rotating mode, each rising edge of the line's qualified level (input high, unmasked, enabled) picks the next set mask bit above the last core served, wrapping from the top core to core 0. The first pick after reset starts from core 0.
- R6: While the qualified level stays high, the rotating grant is held on the same core. It drops in the cycle after the level falls, and it never moves to a new core within one assertion.
- R7: If the destination mask is empty, no uplink is asserted in either mode. This includes clearing the mask while a grant is held.
- R8: Shared line i drives output bit k*NUM_IRQ+i for core k. Lines are routed independently of one another.
- R9: Opcode 3 (mode) selects fixed mode when data bits [1:0] equal 1 and rotating mode for any other value. All other data bits have no effect.
- R10: Uplinks are registered: an input or configuration change shows on the uplinks one clock edge after it is sampled, and not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 3 | Opcode: 1 enable, 2 destination, 3 mode, 4 mask |
| cmd_irq_i | input | IRQ_W | Number of the shared line addressed |
| cmd_data_i | input | DATA_W | Command data word |
| irq_i | input | NUM_IRQ | Shared interrupt levels |
| irq_o | output | NUM_CORE*NUM_IRQ | Per-core uplinks, bit k*NUM_IRQ+i for line i on core k |

## Verification
The assertions assume that the interrupt inputs are level signals sampled on the clock, and that commands are single-cycle strobes whose opcode and data are valid whenever the strobe is high. The hold check also assumes that software does not enlarge a mask so as to grant a new core within one assertion. The stimulus changes inputs and command fields only on the falling edge, and issues one command at a time. It raises and lowers each line with whole-cycle gaps, so that every rising edge counts as a separate assertion.

// File: rtl/idu_pkg.sv
package idu_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_ENABLE   = 3'd1,
    OP_SET_DEST = 3'd2,
    OP_SET_MODE = 3'd3,
    OP_SET_MASK = 3'd4
  } idu_op_e;

  localparam logic [1:0] DISTRIB_FIXED = 2'd1;
endpackage

// File: rtl/idu_cfg.sv
module idu_cfg
  import idu_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  parameter int IRQ_W    = $clog2(NUM_IRQ)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               cmd_valid_i,
  input  logic [2:0]                         cmd_op_i,
  input  logic [IRQ_W-1:0]                   cmd_irq_i,
  input  logic [DATA_W-1:0]                  cmd_data_i,
  output logic                               en_o,
  output logic [NUM_IRQ-1:0]                 mask_o,
  output logic [NUM_IRQ-1:0]                 fixed_o,
  output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_o
);
  logic data_nz;
  assign data_nz = |cmd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else if (cmd_valid_i && cmd_op_i == OP_ENABLE) en_o <= data_nz;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    logic sel;
    assign sel = cmd_valid_i && (cmd_irq_i == IRQ_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[i]  <= 1'b1;
        fixed_o[i] <= 1'b0;
        dest_o[i]  <= '0;
      end else if (sel) begin
        case (cmd_op_i)
          OP_SET_DEST: dest_o[i]  <= cmd_data_i[NUM_CORE-1:0];
          OP_SET_MODE: fixed_o[i] <= (cmd_data_i[1:0] == DISTRIB_FIXED);
          OP_SET_MASK: mask_o[i]  <= data_nz;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idu_route.sv
module idu_route #(
  parameter int NUM_CORE = 4,
  parameter int CW       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                irq_i,
  input  logic                mask_i,
  input  logic                en_i,
  input  logic                fixed_i,
  input  logic [NUM_CORE-1:0] dest_i,
  output logic [NUM_CORE-1:0] grant_o
);
  logic                act, act_q, rise, found;
  logic [CW-1:0]       last_q, last_d, nxt_idx;
  logic [NUM_CORE-1:0] lowest, grant_d;

  assign act    = irq_i && !mask_i && en_i;
  assign rise   = act && !act_q;
  assign lowest = dest_i & (~dest_i + 1'b1);

  // next set bit strictly above last served, wrapping
  always_comb begin
    found   = 1'b0;
    nxt_idx = last_q;
    for (int k = 1; k <= NUM_CORE; k++) begin
      int idx;
      idx = (int'(last_q) + k) % NUM_CORE;
      if (!found && dest_i[idx]) begin
        found   = 1'b1;
        nxt_idx = CW'(idx);
      end
    end
  end

  always_comb begin
    grant_d = '0;
    last_d  = last_q;
    if (act) begin
      if (fixed_i) begin
        grant_d = lowest;
      end else if (rise) begin
        if (found) begin
          grant_d          = '0;
          grant_d[nxt_idx] = 1'b1;
          last_d           = nxt_idx;
        end
      end else begin
        grant_d = grant_o & dest_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      last_q  <= CW'(NUM_CORE - 1);
      grant_o <= '0;
    end else begin
      act_q   <= act;
      last_q  <= last_d;
      grant_o <= grant_d;
    end
  end

  assert_grant_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> act_q);

  assert_single_core_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o));

  assert_rr_no_new_core_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q) && $past(!fixed_i)) |-> ((grant_o & ~$past(grant_o)) == '0));

  assert_empty_dest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dest_i == '0) |=> (grant_o == '0));
endmodule

// File: rtl/idu_top.sv
module idu_top
  import idu_pkg::*;
#(
  parameter int NUM_IRQ  = 8,
  parameter int NUM_CORE = 4,
  parameter int DATA_W   = 32,
  parameter int IRQ_W    = $clog2(NUM_IRQ)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         cmd_valid_i,
  input  logic [2:0]                   cmd_op_i,
  input  logic [IRQ_W-1:0]             cmd_irq_i,
  input  logic [DATA_W-1:0]            cmd_data_i,
  input  logic [NUM_IRQ-1:0]           irq_i,
  output logic [NUM_CORE*NUM_IRQ-1:0]  irq_o
);
  logic                             en;
  logic [NUM_IRQ-1:0]               mask, fixed;
  logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest, grant;

  idu_cfg #(
    .NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .DATA_W(DATA_W), .IRQ_W(IRQ_W)
  ) u_cfg (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .cmd_irq_i, .cmd_data_i,
    .en_o(en), .mask_o(mask), .fixed_o(fixed), .dest_o(dest)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    idu_route #(.NUM_CORE(NUM_CORE)) u_route (
      .clk_i, .rst_ni,
      .irq_i(irq_i[i]), .mask_i(mask[i]), .en_i(en),
      .fixed_i(fixed[i]), .dest_i(dest[i]), .grant_o(grant[i])
    );
    for (genvar k = 0; k < NUM_CORE; k++) begin : g_core
      assign irq_o[k*NUM_IRQ+i] = grant[i][k];
    end
  end

  assert_off_until_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (irq_o == '0));
endmodule

// File: tb/idu_top_tb_top.sv
module idu_top_tb_top;
  localparam int C = 8;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_ni;
  logic           cmd_valid;
  logic [2:0]     cmd_op;
  logic [2:0]     cmd_irq;
  logic [31:0]    cmd_data;
  logic [C-1:0]   irq;
  logic [N*C-1:0] irq_o;
  int             n_chk = 0;
  int             n_fail = 0;

  always #10 clk = ~clk;

  idu_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_irq_i(cmd_irq), .cmd_data_i(cmd_data), .irq_i(irq), .irq_o(irq_o)
  );

  // {dest[3:0], mode[7:0], expected core vector[3:0]} for line 0
  localparam logic [15:0] VEC [8] = '{
    {4'b0110, 8'h01, 4'b0010},
    {4'b1000, 8'h01, 4'b1000},
    {4'b1111, 8'h01, 4'b0001},
    {4'b0000, 8'h01, 4'b0000},
    {4'b1010, 8'h11, 4'b0010},
    {4'b0100, 8'h12, 4'b0100},
    {4'b0010, 8'h03, 4'b0010},
    {4'b1001, 8'hFD, 4'b0001}
  };

  function automatic logic [N-1:0] cores(int i);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[k] = irq_o[k*C+i];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, int line, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_irq = 3'(line); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  logic [N-1:0] rr_exp [4] = '{4'b0001, 4'b0010, 4'b1000, 4'b0001};

  initial begin
    rst_ni = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_irq = '0; cmd_data = '0; irq = '0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", irq_o, 0);
    rst_ni = 1'b1;

    // R1: masked by default
    cmd(3'd1, 0, 1);
    cmd(3'd2, 0, 32'h1);
    cmd(3'd3, 0, 32'h1);
    irq[0] = 1'b1; @(negedge clk); @(negedge clk);
    check("R1 default masked", irq_o, 0);
    irq[0] = 1'b0;

    // R2: enable gating
    cmd(3'd1, 0, 0);
    cmd(3'd4, 0, 0);
    irq[0] = 1'b1; @(negedge clk); @(negedge clk);
    check("R2 disabled", irq_o, 0);
    cmd(3'd1, 0, 32'h100);
    @(negedge clk);
    check("R2 enabled", 32'(cores(0)), 32'b0001);
    irq[0] = 1'b0; @(negedge clk);

    // R4/R9/R7 vector table on line 0
    foreach (VEC[j]) begin
      cmd(3'd2, 0, {28'd0, VEC[j][15:12]});
      cmd(3'd3, 0, {24'd0, VEC[j][11:4]});
      irq[0] = 1'b1; @(negedge clk);
      check($sformatf("R4 R9 R7 vector %0d", j), 32'(cores(0)), 32'(VEC[j][3:0]));
      irq[0] = 1'b0; @(negedge clk);
      check($sformatf("R6 drop vector %0d", j), irq_o, 0);
    end

    // R3: masking while high
    irq[0] = 1'b1; @(negedge clk);
    check("R3 before mask", 32'(cores(0)), 32'b0001);
    cmd(3'd4, 0, 1);
    @(negedge clk);
    check("R3 masked", irq_o, 0);
    cmd(3'd4, 0, 0);
    @(negedge clk);
    check("R3 unmasked", 32'(cores(0)), 32'b0001);
    irq[0] = 1'b0; @(negedge clk);

    // R5/R6: rotation on line 2 over mask 1011
    cmd(3'd4, 2, 0);
    cmd(3'd2, 2, 32'b1011);
    cmd(3'd3, 2, 0);
    for (int r = 0; r < 4; r++) begin
      irq[2] = 1'b1; @(negedge clk);
      check($sformatf("R5 rotation %0d", r), 32'(cores(2)), 32'(rr_exp[r]));
      repeat (3) @(negedge clk);
      check($sformatf("R6 hold %0d", r), 32'(cores(2)), 32'(rr_exp[r]));
      irq[2] = 1'b0; @(negedge clk);
      check($sformatf("R6 release %0d", r), irq_o, 0);
    end

    // R7: empty mask in rotating mode, and clearing a held grant
    cmd(3'd4, 3, 0);
    cmd(3'd3, 3, 0);
    irq[3] = 1'b1; @(negedge clk);
    check("R7 empty rotating", irq_o, 0);
    irq[2] = 1'b1; @(negedge clk);
    check("R5 next after wrap", 32'(cores(2)), 32'b0010);
    cmd(3'd2, 2, 0);
    @(negedge clk);
    check("R7 cleared while held", irq_o, 0);
    irq[2] = 1'b0; irq[3] = 1'b0;

    // R8: independent lines, bit position k*C+i
    cmd(3'd4, 5, 0); cmd(3'd2, 5, 32'b0100); cmd(3'd3, 5, 1);
    cmd(3'd4, 7, 0); cmd(3'd2, 7, 32'b1000); cmd(3'd3, 7, 1);
    irq[5] = 1'b1; irq[7] = 1'b1;
    #1 check("R10 no same-cycle output", irq_o, 0);
    @(negedge clk);
    check("R8 uplink positions", irq_o, (32'd1 << 21) | (32'd1 << 31));
    irq[7] = 1'b0; @(negedge clk);
    check("R8 independent drop", irq_o, 32'd1 << 21);

    cmd(3'd1, 0, 0);
    @(negedge clk);
    check("R2 disable clears", irq_o, 0);
    irq = '0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule